// File: doc/BRIEF.md
# Low-Power Idle Clock Controller

This block decides when a processor core and its companion timing domains are allowed to advance while the core sits in an idle instruction. A one-cycle idle request either halts the core outright (standard idle) or, when a slow-idle bit accompanies it, lets the core and its serial-clock, clock-output and timer enables all tick once every N fast cycles. N comes from a two-bit code in the request. The block drives clock-enable strobes only. The clock generator that consumes them and the decoder that issues the request sit outside it.

Either idle state lasts with no time limit until an interrupt line whose enable bit is set is high. In standard idle the block leaves on the very next edge. In slow idle interrupts are looked at only on the divided-clock pulse, so leaving can take up to N fast cycles. On leaving, the block raises a one-cycle resume strobe, which tells the core to service the interrupt and carry on past the idle instruction. Cycle-steal requests for DMA and autobuffer transfers receive a one-cycle grant in every state and disturb neither the idle state nor the divider phase.

Top module: `idle_clk_ctrl`

## Requirements
- R1: While the synchronous active-high reset is high and in the cycle after it, the block is running: all four enables are 1, the resume strobe is 0 and the steal grant is 0.
- R2: An idle request with the slow bit at 0, taken in the running state, gives core_ce = 0 from the next cycle while ser_ce, cko_ce and tmr_ce stay 1.
- R3: An interrupt line whose enable bit is 0 has no effect in either idle state. core_ce keeps its idle pattern and no resume strobe appears.
- R4: In standard idle, an interrupt line high with its enable bit at 1 during a cycle returns the block to running on the next edge: from the next cycle, resume is 1 and core_ce is 1.
- R5: Slow idle uses N = 16, 32, 64 or 128 for div_code 00, 01, 10 or 11. With k counting cycles from the entry edge (k = 0 is the cycle after it), all four enables are 1 exactly when k mod N = N-1 and 0 otherwise.
- R6: In slow idle, an enabled interrupt held high from cycle K ends idle on the edge that closes the first pulse cycle at or after K. Resume is therefore seen at cycle k_t+1, where k_t is the smallest k ≥ K with k mod N = N-1, so the latency is at most N cycles.
- R7: A cycle-steal request in any cycle gives steal_gnt = 1 in the next cycle only. It does not change the state and does not move the slow-idle pulse phase.
- R8: An idle request that arrives while already idle is ignored, including any slow bit or code it carries.
- R9: The resume strobe lasts exactly one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast clock |
| rst | input | 1 | Synchronous active-high reset |
| idle_req | input | 1 | One-cycle idle instruction strobe |
| idle_slow | input | 1 | 1 selects slow idle, 0 standard idle |
| div_code | input | 2 | Divisor code: 00=16, 01=32, 10=64, 11=128 |
| irq | input | NUM_IRQ | Interrupt request levels |
| irq_en | input | NUM_IRQ | Per-line enable, 1 = line may wake |
| steal_req | input | 1 | DMA / autobuffer cycle-steal request |
| steal_gnt | output | 1 | One-cycle cycle-steal grant |
| core_ce | output | 1 | Core clock enable |
| ser_ce | output | 1 | Serial clock enable |
| cko_ce | output | 1 | Clock-output enable |
| tmr_ce | output | 1 | Timer tick enable |
| resume | output | 1 | One-cycle strobe: idle ended |

## Verification
State changes and the steal grant are registered, so each is due in the first cycle after the edge that samples its stimulus. The bench drives one fast cycle ahead and samples just after the following edge. The slow-idle enables are combinational from the divide counter, so they follow k mod N with no extra delay. Every vector in the bench table (divisor code, interrupt start cycle K) predicts the exact cycle of the resume strobe from the formula in R6 and checks the enable pattern in every cycle before it. Directed runs cover reset, halting, masked lines, re-requests while idle and steals, each sampled in the cycle its result is due.

// File: rtl/idle_clk_pkg.sv
package idle_clk_pkg;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_HALT = 2'd1,
      ST_SLOW = 2'd2
   } idle_state_e;

endpackage

// File: rtl/idle_div_counter.sv
module idle_div_counter #(
   parameter int BASE_LOG2 = 4,
   parameter int CODE_W    = 2,
   localparam int NUM_CODES = 1 << CODE_W,
   localparam int CNT_W     = BASE_LOG2 + NUM_CODES - 1
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              en,
   input  logic [CODE_W-1:0] code,
   output logic              tick
);

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;
   logic [CNT_W-1:0] lim_tab [NUM_CODES];

   generate
      if (BASE_LOG2 < 1) begin : g_bad_base
         $error("idle_div_counter: BASE_LOG2 must be at least 1");
      end
      if (CODE_W < 1) begin : g_bad_code
         $error("idle_div_counter: CODE_W must be at least 1");
      end
      for (genvar g = 0; g < NUM_CODES; g++) begin : g_lim
         assign lim_tab[g] = CNT_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
      end
   endgenerate

   assign limit = lim_tab[code];
   assign tick  = en && (cnt == limit);

   always_ff @(posedge clk) begin
      if (rst || !en) begin
         cnt <= '0;
      end else if (tick) begin
         cnt <= '0;
      end else begin
         cnt <= cnt + 1'b1;
      end
   end

   a_r5_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
      (en && tick) |=> (cnt == '0));

   a_r5_within_limit: assert property (@(posedge clk) disable iff (rst)
      en |-> (cnt <= limit));

endmodule

// File: rtl/idle_wake_detect.sv
module idle_wake_detect #(
   parameter int NUM_IRQ = 8
) (
   input  logic [NUM_IRQ-1:0] irq,
   input  logic [NUM_IRQ-1:0] irq_en,
   output logic               wake
);

   generate
      if (NUM_IRQ < 1) begin : g_bad_irq
         $error("idle_wake_detect: NUM_IRQ must be at least 1");
      end
   endgenerate

   assign wake = |(irq & irq_en);

endmodule

// File: rtl/idle_ctrl_fsm.sv
module idle_ctrl_fsm
   import idle_clk_pkg::*;
#(
   parameter int CODE_W = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              idle_req,
   input  logic              idle_slow,
   input  logic [CODE_W-1:0] div_code,
   input  logic              wake,
   input  logic              tick,
   output idle_state_e       st,
   output logic [CODE_W-1:0] code_q,
   output logic              resume
);

   always_ff @(posedge clk) begin
      if (rst) begin
         st     <= ST_RUN;
         code_q <= '0;
         resume <= 1'b0;
      end else begin
         resume <= 1'b0;
         case (st)
            ST_RUN: begin
               if (idle_req) begin
                  if (idle_slow) begin
                     st     <= ST_SLOW;
                     code_q <= div_code;
                  end else begin
                     st <= ST_HALT;
                  end
               end
            end
            ST_HALT: begin
               if (wake) begin
                  st     <= ST_RUN;
                  resume <= 1'b1;
               end
            end
            ST_SLOW: begin
               if (tick && wake) begin
                  st     <= ST_RUN;
                  resume <= 1'b1;
               end
            end
            default: st <= ST_RUN;
         endcase
      end
   end

   a_r4_halt_exit: assert property (@(posedge clk) disable iff (rst)
      (st == ST_HALT && wake) |=> (st == ST_RUN && resume));

   a_r6_slow_hold: assert property (@(posedge clk) disable iff (rst)
      (st == ST_SLOW && !tick) |=> (st == ST_SLOW));

   a_r8_code_held: assert property (@(posedge clk) disable iff (rst)
      (st == ST_SLOW) |=> (st != ST_SLOW || $stable(code_q)));

   a_r9_resume_pulse: assert property (@(posedge clk) disable iff (rst)
      resume |=> !resume);

endmodule

// File: rtl/idle_clk_ctrl.sv
module idle_clk_ctrl
   import idle_clk_pkg::*;
#(
   parameter int NUM_IRQ            = 8,
   parameter int BASE_LOG2          = 4,
   parameter int CODE_W             = 2,
   parameter bit HALT_KEEPS_DERIVED = 1'b1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               idle_req,
   input  logic               idle_slow,
   input  logic [CODE_W-1:0]  div_code,
   input  logic [NUM_IRQ-1:0] irq,
   input  logic [NUM_IRQ-1:0] irq_en,
   input  logic               steal_req,
   output logic               steal_gnt,
   output logic               core_ce,
   output logic               ser_ce,
   output logic               cko_ce,
   output logic               tmr_ce,
   output logic               resume
);

   idle_state_e       st;
   logic [CODE_W-1:0] code_q;
   logic              wake;
   logic              tick;
   logic              halt_der;
   logic              der_ce;

   idle_wake_detect #(.NUM_IRQ(NUM_IRQ)) wake_i (
      .irq    (irq),
      .irq_en (irq_en),
      .wake   (wake)
   );

   idle_div_counter #(.BASE_LOG2(BASE_LOG2), .CODE_W(CODE_W)) div_i (
      .clk  (clk),
      .rst  (rst),
      .en   (st == ST_SLOW),
      .code (code_q),
      .tick (tick)
   );

   idle_ctrl_fsm #(.CODE_W(CODE_W)) fsm_i (
      .clk       (clk),
      .rst       (rst),
      .idle_req  (idle_req),
      .idle_slow (idle_slow),
      .div_code  (div_code),
      .wake      (wake),
      .tick      (tick),
      .st        (st),
      .code_q    (code_q),
      .resume    (resume)
   );

   generate
      if (HALT_KEEPS_DERIVED) begin : g_der_run
         assign halt_der = 1'b1;
      end else begin : g_der_stop
         assign halt_der = 1'b0;
      end
   endgenerate

   always_comb begin
      case (st)
         ST_HALT: begin
            core_ce = 1'b0;
            der_ce  = halt_der;
         end
         ST_SLOW: begin
            core_ce = tick;
            der_ce  = tick;
         end
         default: begin
            core_ce = 1'b1;
            der_ce  = 1'b1;
         end
      endcase
   end

   assign ser_ce = der_ce;
   assign cko_ce = der_ce;
   assign tmr_ce = der_ce;

   always_ff @(posedge clk) begin
      if (rst) begin
         steal_gnt <= 1'b0;
      end else begin
         steal_gnt <= steal_req;
      end
   end

   a_r7_steal_grant: assert property (@(posedge clk) disable iff (rst)
      steal_req |=> steal_gnt);

   a_r7_steal_keeps_state: assert property (@(posedge clk) disable iff (rst)
      (steal_req && !wake && st == ST_HALT) |=> (st == ST_HALT));

   a_r2_halt_core_off: assert property (@(posedge clk) disable iff (rst)
      (st == ST_HALT) |-> !core_ce);

   a_r3_no_wake_masked: assert property (@(posedge clk) disable iff (rst)
      (st != ST_RUN && !wake) |=> !resume);

endmodule

// File: tb/idle_clk_ctrl_tb_top.sv
module idle_clk_ctrl_tb_top;

   logic       clk = 1'b0;
   logic       rst;
   logic       idle_req, idle_slow;
   logic [1:0] div_code;
   logic [7:0] irq, irq_en;
   logic       steal_req;
   logic       steal_gnt, core_ce, ser_ce, cko_ce, tmr_ce, resume;

   int total = 0;
   int bad   = 0;

   always #4 clk = ~clk;

   idle_clk_ctrl dut_i (
      .clk(clk), .rst(rst), .idle_req(idle_req), .idle_slow(idle_slow),
      .div_code(div_code), .irq(irq), .irq_en(irq_en), .steal_req(steal_req),
      .steal_gnt(steal_gnt), .core_ce(core_ce), .ser_ce(ser_ce),
      .cko_ce(cko_ce), .tmr_ce(tmr_ce), .resume(resume)
   );

   localparam int NV = 6;
   localparam int VCODE [NV] = '{0, 0, 1, 2, 3, 3};
   localparam int VK    [NV] = '{3, 15, 40, 0, 130, 127};

   task automatic step();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic [3:0] ces();
      return {core_ce, ser_ce, cko_ce, tmr_ce};
   endfunction

   initial begin
      repeat (100000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      rst = 1'b1; idle_req = 0; idle_slow = 0; div_code = 0;
      irq = 0; irq_en = 0; steal_req = 0;
      step(); step();
      // R1: reset state
      chk(ces() == 4'hF && !resume && !steal_gnt, "R1", ces(), 15);
      rst = 1'b0;
      step();
      chk(ces() == 4'hF && !resume, "R1", ces(), 15);

      // R2: standard idle entry
      idle_req = 1; idle_slow = 0;
      step();
      idle_req = 0;
      chk(core_ce == 0 && ser_ce && cko_ce && tmr_ce, "R2", ces(), 7);

      // R3: masked lines in standard idle
      irq = 8'b0010_1000; irq_en = 8'b0000_0000;
      begin
         int errs = 0;
         for (int i = 0; i < 5; i++) begin
            step();
            if (core_ce || resume) errs++;
         end
         chk(errs == 0, "R3", errs, 0);
      end

      // R8: a further idle request while idle is ignored
      idle_req = 1; idle_slow = 1; div_code = 2'b00;
      step();
      idle_req = 0; idle_slow = 0;
      begin
         int errs = 0;
         for (int i = 0; i < 20; i++) begin
            if (core_ce || !ser_ce || resume) errs++;
            step();
         end
         chk(errs == 0, "R8", errs, 0);
      end

      // R7: steal grant in standard idle
      steal_req = 1;
      step();
      steal_req = 0;
      chk(steal_gnt && !core_ce, "R7", {steal_gnt, core_ce}, 2);
      step();
      chk(!steal_gnt && !core_ce, "R7", {steal_gnt, core_ce}, 0);

      // R4: unmasked interrupt ends standard idle next edge
      irq_en = 8'b0000_1000;
      step();
      chk(resume && core_ce, "R4", {resume, core_ce}, 3);
      irq = 0; irq_en = 0;
      step();
      // R9: single-cycle resume
      chk(!resume && core_ce, "R9", {resume, core_ce}, 1);

      // R5/R6/R3: table of slow-idle vectors
      for (int v = 0; v < NV; v++) begin
         int n, kk, kt, due, errs, got;
         n  = 16 << VCODE[v];
         kk = VK[v];
         kt = kk;
         while ((kt % n) != n - 1) kt++;
         due = kt + 1;
         errs = 0; got = -1;
         irq = 8'b0000_0001; irq_en = 8'b0000_0010;
         idle_req = 1; idle_slow = 1; div_code = 2'(VCODE[v]);
         step();
         idle_req = 0; idle_slow = 0;
         for (int k = 0; k < 400; k++) begin
            if (resume) begin
               got = k;
               break;
            end
            if (ces() != (((k % n) == n - 1) ? 4'hF : 4'h0)) errs++;
            if (k == kk) irq = 8'b0000_0011;
            step();
         end
         chk(errs == 0, "R5", errs, 0);
         chk(got == due, "R6", got, due);
         chk(got - kk <= n, "R6", got - kk, n);
         irq = 0; irq_en = 0;
         step();
         chk(!resume && core_ce, "R9", {resume, core_ce}, 1);
      end

      // R7: steal during slow idle keeps the pulse phase
      idle_req = 1; idle_slow = 1; div_code = 2'b00;
      step();
      idle_req = 0; idle_slow = 0;
      begin
         int errs = 0;
         for (int k = 0; k < 32; k++) begin
            if (k == 6 && !steal_gnt) errs++;
            if (k == 7 && steal_gnt) errs++;
            if (ces() != (((k % 16) == 15) ? 4'hF : 4'h0)) errs++;
            steal_req = (k == 5);
            step();
         end
         chk(errs == 0, "R7", errs, 0);
      end
      // wake from there: k = 32, pulse at 47, resume at 48
      irq = 8'b1000_0000; irq_en = 8'b1000_0000;
      begin
         int got = -1;
         for (int k = 32; k < 80; k++) begin
            if (resume) begin
               got = k;
               break;
            end
            step();
         end
         chk(got == 48, "R6", got, 48);
      end
      irq = 0; irq_en = 0;
      step();

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule